// File: doc/BRIEF.md
# Privileged Special Register Access Controller

This block holds a small file of special registers behind a permission check. Software reaches the registers through four operations. A read and a write take their index from a register operand. An immediate read and an immediate write take it from an instruction immediate. Every access is checked against the caller's privilege level before it takes effect.

The registers fall into four groups, laid out in index order:

| Indices | Group | Rules |
|---------|-------|-------|
| 0–3 | Hardwired | Fixed descriptive values, read-only for everyone. |
| 4–7 | Supervisor-controlled | Writable by privileged code, or by unprivileged code when that register's grant bit is set. |
| 8–11 | User-controlled | Open to every privilege level. |
| 12 | Grant register | One bit per supervisor-controlled register. |

Unprivileged code may only lower grant bits, never raise them. A refused or out-of-range access raises a trap with a cause code, and nothing in the file changes.

Requests arrive on a valid/stall handshake. A request is taken on a rising edge where `req_valid` is high and `stall` is low. The following cycle is the check cycle: `stall` is high then and no new request is taken. A requester that still wants to issue must hold its request until `stall` falls. The outcome appears one cycle after the check cycle as a one-cycle `rsp_valid` pulse, carrying read data, trap flag and cause. There is no response back-pressure.

Top module: `sra_ctrl`

## Requirements
- R1: Operation codes are 0 = get, 1 = put, 2 = immediate get, 3 = immediate put. Codes 0 and 1 use `req_idx_reg` as the index; codes 2 and 3 use `req_idx_imm`.
- R2: A request is taken when `req_valid` is high and `stall` is low at a rising edge. `stall` is high for exactly the next cycle, and the response (`rsp_valid` high with data, trap and cause) appears in the cycle after that. A request presented while `stall` is high is not taken.
- R3: Indices 0..3 read as, in order: the revision parameter, the implemented register count (13), the data width (32) and the unit-flag parameter. A put to any of them traps with cause 1 and changes nothing.
- R4: Indices 4..7 are readable at any privilege. A privileged put writes them. An unprivileged put without the matching grant bit traps with cause 1 and leaves the register unchanged.
- R5: Indices 8..11 are read and written at any privilege without a trap.
- R6: Bit k of the grant register (index 12) enables unprivileged puts to index 4+k. Once the bit is cleared, such puts trap again with cause 1.
- R7: A privileged put to index 12 loads the grant bits with any value. An unprivileged put succeeds only if it sets no bit that is currently clear; otherwise it traps with cause 1 and the grant bits stay unchanged.
- R8: Any operation with an index of 13 or above traps with cause 2 and changes nothing.
- R9: Reset clears all supervisor-controlled registers, all user-controlled registers and the grant bits. The hardwired values remain readable after reset.
- R10: `rsp_rdata` carries the register value only for a successful get or immediate get, and is zero for puts and traps. `trap_cause` is 0 whenever `trap` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (R1) |
| req_idx_reg | input | IDX_W | Index from a register operand |
| req_idx_imm | input | IDX_W | Index from an immediate |
| req_wdata | input | DW | Write data for puts |
| req_priv | input | 1 | Caller is privileged |
| stall | output | 1 | Check in progress; no request is taken |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DW | Read data |
| trap | output | 1 | Access refused |
| trap_cause | output | 2 | 0 none, 1 privilege, 2 index range |

## Verification
The assertions assume that reset is applied before the first request. They also assume that the request fields carry no unknown values while `req_valid` is high. Under those conditions, the one-cycle stall, the response that follows it, the zero read data on a trap, and the rule that grant bits never rise on an unprivileged commit all follow from the design.

The stimulus changes inputs only on falling edges. It lowers `req_valid` during each check cycle, except in one directed case. In that case it deliberately holds a different request across the stall, to show that the request is not taken.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic [1:0] {
    OP_GET  = 2'd0,
    OP_PUT  = 2'd1,
    OP_GETI = 2'd2,
    OP_PUTI = 2'd3
  } sra_op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_PRIV  = 2'd1,
    CAUSE_RANGE = 2'd2
  } sra_cause_e;

  typedef enum logic [2:0] {
    CLS_HW    = 3'd0,
    CLS_SUP   = 3'd1,
    CLS_USR   = 3'd2,
    CLS_GRANT = 3'd3,
    CLS_NONE  = 3'd4
  } sra_class_e;

endpackage

// File: rtl/sra_decode.sv
module sra_decode
  import sra_pkg::*;
#(
  parameter int N_HW  = 4,
  parameter int N_SUP = 4,
  parameter int N_USR = 4,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output sra_class_e       cls,
  output logic [IDX_W-1:0] slot
);
  localparam int SUP_BASE  = N_HW;
  localparam int USR_BASE  = N_HW + N_SUP;
  localparam int GRANT_IDX = N_HW + N_SUP + N_USR;

  always_comb begin
    cls  = CLS_NONE;
    slot = '0;
    if (idx < IDX_W'(SUP_BASE)) begin
      cls  = CLS_HW;
      slot = idx;
    end else if (idx < IDX_W'(USR_BASE)) begin
      cls  = CLS_SUP;
      slot = idx - IDX_W'(SUP_BASE);
    end else if (idx < IDX_W'(GRANT_IDX)) begin
      cls  = CLS_USR;
      slot = idx - IDX_W'(USR_BASE);
    end else if (idx == IDX_W'(GRANT_IDX)) begin
      cls  = CLS_GRANT;
    end
  end

endmodule

// File: rtl/sra_policy.sv
module sra_policy
  import sra_pkg::*;
#(
  parameter int N_SUP = 4,
  parameter int IDX_W = 4,
  parameter int DW    = 32
) (
  input  sra_class_e       cls,
  input  logic [IDX_W-1:0] slot,
  input  logic             is_write,
  input  logic             priv,
  input  logic [N_SUP-1:0] grant,
  input  logic [DW-1:0]    wdata,
  output logic             allow,
  output sra_cause_e       cause
);
  logic [N_SUP-1:0] grant_sh;
  logic [N_SUP-1:0] raise_bits;

  assign grant_sh   = grant >> slot;
  assign raise_bits = wdata[N_SUP-1:0] & ~grant;

  always_comb begin
    allow = 1'b1;
    cause = CAUSE_NONE;
    unique case (cls)
      CLS_NONE: begin
        allow = 1'b0;
        cause = CAUSE_RANGE;
      end
      CLS_HW: begin
        if (is_write) begin
          allow = 1'b0;
          cause = CAUSE_PRIV;
        end
      end
      CLS_SUP: begin
        if (is_write && !priv && !grant_sh[0]) begin
          allow = 1'b0;
          cause = CAUSE_PRIV;
        end
      end
      CLS_GRANT: begin
        if (is_write && !priv && (|raise_bits)) begin
          allow = 1'b0;
          cause = CAUSE_PRIV;
        end
      end
      default: begin
        allow = 1'b1;
        cause = CAUSE_NONE;
      end
    endcase
  end

endmodule

// File: rtl/sra_regfile.sv
module sra_regfile
  import sra_pkg::*;
#(
  parameter int          N_HW       = 4,
  parameter int          N_SUP      = 4,
  parameter int          N_USR      = 4,
  parameter int          IDX_W      = 4,
  parameter int          DW         = 32,
  parameter logic [31:0] REV_CODE   = 32'h0000_0A01,
  parameter logic [31:0] UNIT_FLAGS = 32'h0000_001F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  sra_class_e       cls,
  input  logic [IDX_W-1:0] slot,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [N_SUP-1:0] grant
);
  localparam int TOTAL = N_HW + N_SUP + N_USR + 1;

  logic [DW-1:0]    sup_q [N_SUP];
  logic [DW-1:0]    usr_q [N_USR];
  logic [N_SUP-1:0] grant_q;
  logic [DW-1:0]    hw_val [N_HW];

  // hardwired descriptive values
  always_comb begin
    for (int k = 0; k < N_HW; k++) hw_val[k] = '0;
    hw_val[0] = DW'(REV_CODE);
    hw_val[1] = DW'(TOTAL);
    hw_val[2] = DW'(DW);
    hw_val[3] = DW'(UNIT_FLAGS);
  end

  generate
    for (genvar k = 0; k < N_SUP; k++) begin : g_sup
      always_ff @(posedge clk) begin
        if (!rst_n) sup_q[k] <= '0;
        else if (we && cls == CLS_SUP && slot == IDX_W'(k)) sup_q[k] <= wdata;
      end
    end
    for (genvar k = 0; k < N_USR; k++) begin : g_usr
      always_ff @(posedge clk) begin
        if (!rst_n) usr_q[k] <= '0;
        else if (we && cls == CLS_USR && slot == IDX_W'(k)) usr_q[k] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) grant_q <= '0;
    else if (we && cls == CLS_GRANT) grant_q <= wdata[N_SUP-1:0];
  end

  assign grant = grant_q;

  always_comb begin
    rdata = '0;
    unique case (cls)
      CLS_HW:    for (int k = 0; k < N_HW; k++)  if (slot == IDX_W'(k)) rdata = hw_val[k];
      CLS_SUP:   for (int k = 0; k < N_SUP; k++) if (slot == IDX_W'(k)) rdata = sup_q[k];
      CLS_USR:   for (int k = 0; k < N_USR; k++) if (slot == IDX_W'(k)) rdata = usr_q[k];
      CLS_GRANT: rdata = DW'(grant_q);
      default:   rdata = '0;
    endcase
  end

  // R3
  hw_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && cls == CLS_HW));

endmodule

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
#(
  parameter int          N_SUP      = 4,
  parameter int          N_USR      = 4,
  parameter int          IDX_W      = 4,
  parameter int          DW         = 32,
  parameter logic [31:0] REV_CODE   = 32'h0000_0A01,
  parameter logic [31:0] UNIT_FLAGS = 32'h0000_001F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx_reg,
  input  logic [IDX_W-1:0] req_idx_imm,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_priv,
  output logic             stall,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             trap,
  output logic [1:0]       trap_cause
);
  localparam int N_HW = 4;

  sra_op_e          op_in;
  logic             take;
  logic [IDX_W-1:0] sel_idx;

  logic             s1_valid;
  logic [IDX_W-1:0] s1_idx;
  logic             s1_write;
  logic [DW-1:0]    s1_wdata;
  logic             s1_priv;

  sra_class_e       dec_cls;
  logic [IDX_W-1:0] dec_slot;
  logic             pol_allow;
  sra_cause_e       pol_cause;
  logic [DW-1:0]    rf_rdata;
  logic [N_SUP-1:0] rf_grant;
  logic             rf_we;

  assign op_in   = sra_op_e'(req_op);
  assign take    = req_valid && !s1_valid;
  assign sel_idx = (op_in == OP_GETI || op_in == OP_PUTI) ? req_idx_imm : req_idx_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
      s1_write <= 1'b0;
      s1_wdata <= '0;
      s1_priv  <= 1'b0;
    end else begin
      s1_valid <= take;
      if (take) begin
        s1_idx   <= sel_idx;
        s1_write <= (op_in == OP_PUT || op_in == OP_PUTI);
        s1_wdata <= req_wdata;
        s1_priv  <= req_priv;
      end
    end
  end

  sra_decode #(.N_HW(N_HW), .N_SUP(N_SUP), .N_USR(N_USR), .IDX_W(IDX_W)) i_decode (
    .idx  (s1_idx),
    .cls  (dec_cls),
    .slot (dec_slot)
  );

  sra_policy #(.N_SUP(N_SUP), .IDX_W(IDX_W), .DW(DW)) i_policy (
    .cls      (dec_cls),
    .slot     (dec_slot),
    .is_write (s1_write),
    .priv     (s1_priv),
    .grant    (rf_grant),
    .wdata    (s1_wdata),
    .allow    (pol_allow),
    .cause    (pol_cause)
  );

  assign rf_we = s1_valid && s1_write && pol_allow;

  sra_regfile #(
    .N_HW(N_HW), .N_SUP(N_SUP), .N_USR(N_USR), .IDX_W(IDX_W), .DW(DW),
    .REV_CODE(REV_CODE), .UNIT_FLAGS(UNIT_FLAGS)
  ) i_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .cls   (dec_cls),
    .slot  (dec_slot),
    .wdata (s1_wdata),
    .rdata (rf_rdata),
    .grant (rf_grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      trap       <= 1'b0;
      trap_cause <= CAUSE_NONE;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        trap       <= !pol_allow;
        trap_cause <= pol_cause;
        rsp_rdata  <= (pol_allow && !s1_write) ? rf_rdata : '0;
      end else begin
        trap       <= 1'b0;
        trap_cause <= CAUSE_NONE;
        rsp_rdata  <= '0;
      end
    end
  end

  assign stall = s1_valid;

  // R2
  stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R2
  rsp_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> rsp_valid);

  // R10
  trap_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (rsp_rdata == '0 && rsp_valid));

  // R10
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> (trap_cause == CAUSE_NONE));

  // R7
  grant_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && dec_cls == CLS_GRANT && !s1_priv) |=> ((rf_grant & ~$past(rf_grant)) == '0));

endmodule

// File: tb/test_sra_ctrl.sv
module test_sra_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [3:0]  req_idx_reg = '0;
  logic [3:0]  req_idx_imm = '0;
  logic [31:0] req_wdata = '0;
  logic        req_priv = 1'b0;
  logic        stall;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        trap;
  logic [1:0]  trap_cause;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sra_ctrl i_sra_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_idx_reg(req_idx_reg), .req_idx_imm(req_idx_imm), .req_wdata(req_wdata),
    .req_priv(req_priv), .stall(stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .trap(trap), .trap_cause(trap_cause)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  ir;
    logic [3:0]  ii;
    logic [31:0] wd;
    logic        pv;
    logic        et;
    logic [1:0]  ec;
    logic [31:0] erd;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0,  4'd5,  32'h0,      1'b0, 1'b0, 2'd0, 32'h0000_0A01, 8'd1},  // R1 R3 get uses reg index
    '{2'd2, 4'd0,  4'd1,  32'h0,      1'b0, 1'b0, 2'd0, 32'd13,        8'd1},  // R1 R3 geti uses imm index
    '{2'd2, 4'd7,  4'd2,  32'h0,      1'b0, 1'b0, 2'd0, 32'd32,        8'd3},  // R3
    '{2'd0, 4'd3,  4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h0000_001F, 8'd3},  // R3
    '{2'd1, 4'd0,  4'd0,  32'h5,      1'b1, 1'b1, 2'd1, 32'h0,         8'd3},  // R3 put hw traps
    '{2'd0, 4'd0,  4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h0000_0A01, 8'd3},  // R3 unchanged
    '{2'd0, 4'd4,  4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h0,         8'd9},  // R9 reset zero
    '{2'd1, 4'd4,  4'd0,  32'h1111,   1'b0, 1'b1, 2'd1, 32'h0,         8'd4},  // R4 unpriv put
    '{2'd0, 4'd4,  4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h0,         8'd4},  // R4 unchanged
    '{2'd3, 4'd0,  4'd4,  32'h1111,   1'b1, 1'b0, 2'd0, 32'h0,         8'd10}, // R4 R10 priv puti
    '{2'd0, 4'd4,  4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h1111,      8'd4},  // R4 readback
    '{2'd1, 4'd9,  4'd0,  32'hBEEF,   1'b0, 1'b0, 2'd0, 32'h0,         8'd5},  // R5
    '{2'd2, 4'd0,  4'd9,  32'h0,      1'b0, 1'b0, 2'd0, 32'hBEEF,      8'd5},  // R5
    '{2'd0, 4'd8,  4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h0,         8'd9},  // R9
    '{2'd1, 4'd12, 4'd0,  32'h2,      1'b0, 1'b1, 2'd1, 32'h0,         8'd7},  // R7 raise refused
    '{2'd0, 4'd12, 4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h0,         8'd7},  // R7 unchanged
    '{2'd1, 4'd12, 4'd0,  32'h6,      1'b1, 1'b0, 2'd0, 32'h0,         8'd7},  // R7 priv grant
    '{2'd1, 4'd5,  4'd0,  32'h55,     1'b0, 1'b0, 2'd0, 32'h0,         8'd6},  // R6 granted
    '{2'd0, 4'd5,  4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h55,        8'd6},  // R6
    '{2'd1, 4'd7,  4'd0,  32'h77,     1'b0, 1'b1, 2'd1, 32'h0,         8'd6},  // R6 bit3 clear
    '{2'd1, 4'd12, 4'd0,  32'h4,      1'b0, 1'b0, 2'd0, 32'h0,         8'd7},  // R7 unpriv clear
    '{2'd0, 4'd12, 4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h4,         8'd7},  // R7
    '{2'd1, 4'd5,  4'd0,  32'h99,     1'b0, 1'b1, 2'd1, 32'h0,         8'd6},  // R6 revoked
    '{2'd0, 4'd5,  4'd0,  32'h0,      1'b0, 1'b0, 2'd0, 32'h55,        8'd6},  // R6 unchanged
    '{2'd3, 4'd0,  4'd12, 32'h5,      1'b0, 1'b1, 2'd1, 32'h0,         8'd7},  // R7 mixed raise
    '{2'd0, 4'd13, 4'd0,  32'h0,      1'b1, 1'b1, 2'd2, 32'h0,         8'd8},  // R8
    '{2'd3, 4'd0,  4'd15, 32'h1,      1'b1, 1'b1, 2'd2, 32'h0,         8'd8},  // R8
    '{2'd0, 4'd6,  4'd0,  32'h0,      1'b1, 1'b0, 2'd0, 32'h0,         8'd4},  // R4 priv read
    '{2'd1, 4'd0,  4'd3,  32'h0,      1'b0, 1'b1, 2'd1, 32'h0,         8'd3}   // R3 unpriv put hw
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [1:0] op, input logic [3:0] ir, input logic [3:0] ii,
                         input logic [31:0] wd, input logic pv, input logic et,
                         input logic [1:0] ec, input logic [31:0] erd, input int rq);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_idx_reg = ir; req_idx_imm = ii;
    req_wdata = wd; req_priv = pv;
    @(negedge clk);
    chk(stall === 1'b1 && rsp_valid === 1'b0, 2, "stall in check cycle", {31'd0, stall}, 32'd1); // R2
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid === 1'b1 && stall === 1'b0, 2, "rsp_valid", {31'd0, rsp_valid}, 32'd1);      // R2
    chk(trap === et && trap_cause === ec && rsp_rdata === erd, rq, "trap/cause/rdata",
        {rsp_rdata[27:0], 1'b0, trap, trap_cause}, {erd[27:0], 1'b0, et, ec});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=hang expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9 reset state of outputs
    chk(stall === 1'b0 && rsp_valid === 1'b0 && trap === 1'b0, 9, "outputs in reset",
        {29'd0, stall, rsp_valid, trap}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stall === 1'b0 && rsp_valid === 1'b0, 2, "idle after reset", {30'd0, stall, rsp_valid}, 32'd0);

    for (int v = 0; v < NV; v++)
      run_vec(VECS[v].op, VECS[v].ir, VECS[v].ii, VECS[v].wd, VECS[v].pv,
              VECS[v].et, VECS[v].ec, VECS[v].erd, int'(VECS[v].rq));

    // R2: a request held across the stall cycle is not taken
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_idx_reg = 4'd10; req_wdata = 32'h10; req_priv = 1'b0;
    @(negedge clk);
    req_wdata = 32'h20; // different request while stalled
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && trap === 1'b0, 2, "first response", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    chk(rsp_valid === 1'b0 && stall === 1'b0, 2, "no second request taken",
        {30'd0, rsp_valid, stall}, 32'd0);
    run_vec(2'd0, 4'd10, 4'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h10, 2);  // R2 value of first only

    // R9: reset clears writable state, hardwired survives
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_vec(2'd0, 4'd4,  4'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0,         9);  // R9
    run_vec(2'd0, 4'd9,  4'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0,         9);  // R9
    run_vec(2'd0, 4'd12, 4'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0,         9);  // R9
    run_vec(2'd0, 4'd5,  4'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0,         9);  // R9
    run_vec(2'd0, 4'd0,  4'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0000_0A01, 9);  // R9 hardwired

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule